// File: doc/BRIEF.md
# Asynchronous Bus Cycle Sequencer

This block is a bus master for an asynchronous, strobe-handshaked 16-bit memory bus. An internal requester hands it one command at a time: a read, a write, or an indivisible read-modify-write, with a word address, two byte-lane enables and write data. The sequencer then walks a fixed run of states, one system clock each. These states are called S0 to S7, and wait pairs W0/W1 can be inserted between S4 and S5. The state decides the address bus, its output enable, the active-low address strobe, the upper and lower data strobes, the read/write line and the write-data output enable.

The slave answers with an active-low acknowledge. This acknowledge is re-timed by a two-flop synchronizer before the state machine looks at it. Until the acknowledge is seen, the sequencer holds its strobes and inserts wait states in pairs. Read data is captured on the clock edge that enters S6. It is returned with a one-cycle response pulse in S7. Bytes in lanes that were not enabled are returned as zero.

The command side is a valid/ready stream. `cmd_ready` is high only while the sequencer is idle, and a command transfers on a cycle where `cmd_valid` and `cmd_ready` are both high. A requester that sees `cmd_ready` low must hold its command stable. The response side has no back-pressure: `rsp_valid` is a single-cycle pulse that the requester must take when it appears.

Top module: `abus_master`

## Requirements
- R1: During and straight after reset, `cmd_ready` is 1, `bus_as_n`, `bus_uds_n`, `bus_lds_n` and `bus_rw_n` are 1, `bus_addr_oe`, `bus_data_oe` and `rsp_valid` are 0.
- R2: A command is taken on a cycle where `cmd_valid` and `cmd_ready` are both 1; `cmd_ready` stays 0 from the next cycle until the sequencer is idle again. Opcode 00 is a read, 01 a write, 10 a read-modify-write and 11 also a read. Address, enables and write data are captured at acceptance.
- R3: The cycle after acceptance is S0, with the address bus floated (`bus_addr_oe` 0, `bus_addr` 0). From S1 on, the accepted address is driven and held stable until the command's response cycle.
- R4: `bus_as_n` goes low in S2, once the address has been valid for a cycle. It stays low through S6 and any wait states, and is high in S7 of a plain read or write.
- R5: Lane enable bit 1 selects the upper lane, data bits 15:8, on `bus_uds_n`. Bit 0 selects the lower lane, bits 7:0, on `bus_lds_n`. Enables 00 act as 11. In a read phase, the selected strobes fall together with `bus_as_n` and stay low through S6.
- R6: `bus_dtack_n` passes two flops. A low level sampled at edge n is seen by the state machine from the cycle after edge n+1. It is tested in S4 and in each W1, and every miss adds a W0/W1 pair. With a slave that pulls acknowledge low d cycles after a read strobe falls, the response pulse comes in cycle 8+2*ceil(d/2) after acceptance (S0 being cycle 1).
- R7: Read data on `bus_rdata` is captured at the edge that moves S5 to S6. It appears on `rsp_data` with disabled lanes zeroed, during a one-cycle `rsp_valid` in the final S7.
- R8: In a write, `bus_rw_n` is low from S2 through S7 and `bus_data_oe` is high from S3 through S7, driving the accepted write data. The selected strobes are low from S4 through S6, plus wait states. `rsp_data` is 0. Under the R6 slave, the response pulse comes in cycle 10+2*ceil(d/2).
- R9: A read-modify-write runs a read phase S0–S7 and then a write phase S2–S7 at the same address. `bus_as_n` stays low from the read-phase S2 until the write-phase S7. `bus_rw_n` is high for the read and low for the write, and the data strobes give two separate pulses. The response returns the read-phase data. Under the R6 slave, it comes in cycle 16+4*ceil(d/2).
- R10: In the cycle after the response pulse, every strobe and `bus_rw_n` are high and both output enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one bus state per period |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle and able to take a command |
| cmd_op | input | 2 | 00 read, 01 write, 10 read-modify-write, 11 read |
| cmd_addr | input | ADDR_W | Word address |
| cmd_be | input | 2 | Lane enables, bit 1 upper, bit 0 lower |
| cmd_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_data | output | DATA_W | Captured read data, disabled lanes zero |
| bus_addr | output | ADDR_W | Address bus, 0 while floated |
| bus_addr_oe | output | 1 | Address bus output enable |
| bus_as_n | output | 1 | Address strobe, active low |
| bus_uds_n | output | 1 | Upper-lane data strobe, active low |
| bus_lds_n | output | 1 | Lower-lane data strobe, active low |
| bus_rw_n | output | 1 | High for read, low for write |
| bus_wdata | output | DATA_W | Write data bus, 0 when not driven |
| bus_data_oe | output | 1 | Write data output enable |
| bus_rdata | input | DATA_W | Read data from the slave |
| bus_dtack_n | input | 1 | Slave acknowledge, active low, asynchronous |

## Verification
In a read-modify-write, two events can land in the same cycle: the read phase's acknowledge is still in the synchronizer, and the write phase tests for its own acknowledge. A stale low level reaching the S4 test of the write phase would end that phase before the slave has stored the data. This is provoked by running read-modify-write commands against a zero-delay slave, where the release of the first acknowledge and the test in the second phase are as close as they get, and also against slower slaves. The bench judges it by the response latency, by counting two separate strobe pulses with the expected number of read-level and write-level strobe cycles, and by reading the location back afterwards.

// File: rtl/abus_pkg.sv
package abus_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_S0,
    ST_S1,
    ST_S2,
    ST_S3,
    ST_S4,
    ST_W0,
    ST_W1,
    ST_S5,
    ST_S6,
    ST_S7
  } bus_state_e;

  typedef enum logic [1:0] {
    OP_READ     = 2'b00,
    OP_WRITE    = 2'b01,
    OP_RMW      = 2'b10,
    OP_READ_ALT = 2'b11
  } bus_op_e;

  localparam int unsigned LANES = 2;

  // Enables of 00 would leave the slave without a strobe; widen to a word.
  function automatic logic [LANES-1:0] lanes_of(input logic [LANES-1:0] be);
    return (be == '0) ? '1 : be;
  endfunction

endpackage

// File: rtl/abus_sync.sv
module abus_sync #(
  parameter int unsigned STAGES   = 2,
  parameter bit          IDLE_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic q_out
);

  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[i] <= IDLE_VAL;
          else        chain_q[i] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[i] <= IDLE_VAL;
          else        chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign q_out = chain_q[STAGES-1];

endmodule

// File: rtl/abus_fsm.sv
module abus_fsm
  import abus_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [1:0] op,
  input  logic       ack,
  output bus_state_e st,
  output logic       wr_phase,
  output logic       rmw,
  output logic       capture,
  output logic       done
);

  bus_state_e st_q, st_d;
  logic       wr_q, wr_d;
  logic       rmw_q, rmw_d;

  always_comb begin
    st_d  = st_q;
    wr_d  = wr_q;
    rmw_d = rmw_q;
    unique case (st_q)
      ST_IDLE: if (start) begin
        st_d  = ST_S0;
        wr_d  = (op == OP_WRITE);
        rmw_d = (op == OP_RMW);
      end
      ST_S0: st_d = ST_S1;
      ST_S1: st_d = ST_S2;
      ST_S2: st_d = ST_S3;
      ST_S3: st_d = ST_S4;
      ST_S4: st_d = ack ? ST_S5 : ST_W0;
      ST_W0: st_d = ST_W1;
      ST_W1: st_d = ack ? ST_S5 : ST_W0;
      ST_S5: st_d = ST_S6;
      ST_S6: st_d = ST_S7;
      ST_S7: begin
        if (rmw_q && !wr_q) begin
          // second half of the locked pair: address already out, strobe held
          st_d = ST_S2;
          wr_d = 1'b1;
        end else begin
          st_d  = ST_IDLE;
          wr_d  = 1'b0;
          rmw_d = 1'b0;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      wr_q  <= 1'b0;
      rmw_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      wr_q  <= wr_d;
      rmw_q <= rmw_d;
    end
  end

  assign st       = st_q;
  assign wr_phase = wr_q;
  assign rmw      = rmw_q;
  assign capture  = (st_q == ST_S5) && !wr_q;
  assign done     = (st_q == ST_S7) && (!rmw_q || wr_q);

endmodule

// File: rtl/abus_drive.sv
module abus_drive
  import abus_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [LANES-1:0]  cmd_be,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  bus_state_e        st,
  input  logic              wr_phase,
  input  logic              rmw,
  input  logic              capture,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_addr_oe,
  output logic              bus_as_n,
  output logic              bus_uds_n,
  output logic              bus_lds_n,
  output logic              bus_rw_n,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_data_oe,
  output logic [DATA_W-1:0] rdata
);

  localparam int unsigned LANE_W = DATA_W / LANES;

  logic [ADDR_W-1:0] addr_q;
  logic [LANES-1:0]  lanes_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] lane_mask;

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_mask
      assign lane_mask[l*LANE_W +: LANE_W] = {LANE_W{lanes_q[l]}};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      lanes_q <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else if (start) begin
      addr_q  <= cmd_addr;
      lanes_q <= lanes_of(cmd_be);
      wdata_q <= cmd_wdata;
      rdata_q <= '0;
    end else if (capture) begin
      rdata_q <= bus_rdata & lane_mask;
    end
  end

  logic in_access;   // S2..S6 and wait states
  logic addr_on;
  logic as_on;
  logic ds_on;
  logic wr_on;
  logic dat_on;

  always_comb begin
    in_access = 1'b0;
    unique case (st)
      ST_S2, ST_S3, ST_S4, ST_W0, ST_W1, ST_S5, ST_S6: in_access = 1'b1;
      default:                                         in_access = 1'b0;
    endcase

    addr_on = (st != ST_IDLE) && (st != ST_S0);
    as_on   = in_access || ((st == ST_S7) && rmw && !wr_phase);

    if (wr_phase) begin
      // data goes out one state before the strobes
      ds_on  = in_access && (st != ST_S2) && (st != ST_S3);
      dat_on = (in_access && (st != ST_S2)) || (st == ST_S7);
      wr_on  = in_access || (st == ST_S7);
    end else begin
      ds_on  = in_access;
      dat_on = 1'b0;
      wr_on  = 1'b0;
    end
  end

  assign bus_addr_oe = addr_on;
  assign bus_addr    = addr_on ? addr_q : '0;
  assign bus_as_n    = !as_on;
  assign bus_uds_n   = !(ds_on && lanes_q[1]);
  assign bus_lds_n   = !(ds_on && lanes_q[0]);
  assign bus_rw_n    = !wr_on;
  assign bus_data_oe = dat_on;
  assign bus_wdata   = dat_on ? wdata_q : '0;
  assign rdata       = rdata_q;

endmodule

// File: rtl/abus_master.sv
module abus_master
  import abus_pkg::*;
#(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [1:0]        cmd_be,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_addr_oe,
  output logic              bus_as_n,
  output logic              bus_uds_n,
  output logic              bus_lds_n,
  output logic              bus_rw_n,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_data_oe,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_dtack_n
);

  bus_state_e st;
  logic       wr_phase;
  logic       rmw;
  logic       capture;
  logic       done;
  logic       dtack_s_n;
  logic       start;

  assign cmd_ready = (st == ST_IDLE);
  assign start     = cmd_valid && cmd_ready;

  abus_sync #(
    .STAGES  (SYNC_STAGES),
    .IDLE_VAL(1'b1)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_in (bus_dtack_n),
    .q_out(dtack_s_n)
  );

  abus_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .op      (cmd_op),
    .ack     (!dtack_s_n),
    .st      (st),
    .wr_phase(wr_phase),
    .rmw     (rmw),
    .capture (capture),
    .done    (done)
  );

  abus_drive #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_drive (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .cmd_addr   (cmd_addr),
    .cmd_be     (cmd_be),
    .cmd_wdata  (cmd_wdata),
    .st         (st),
    .wr_phase   (wr_phase),
    .rmw        (rmw),
    .capture    (capture),
    .bus_rdata  (bus_rdata),
    .bus_addr   (bus_addr),
    .bus_addr_oe(bus_addr_oe),
    .bus_as_n   (bus_as_n),
    .bus_uds_n  (bus_uds_n),
    .bus_lds_n  (bus_lds_n),
    .bus_rw_n   (bus_rw_n),
    .bus_wdata  (bus_wdata),
    .bus_data_oe(bus_data_oe),
    .rdata      (rsp_data)
  );

  assign rsp_valid = done;

endmodule

// File: rtl/abus_master_chk.sv
module abus_master_chk #(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_addr_oe,
  input logic              bus_as_n,
  input logic              bus_uds_n,
  input logic              bus_lds_n,
  input logic              bus_rw_n,
  input logic              bus_data_oe
);

  // R2: no new command while the strobe is out
  assert_busy_while_strobed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_as_n |-> !cmd_ready);

  // R3: address held while the strobe stays low
  assert_addr_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_as_n && !$past(bus_as_n)) |-> $stable(bus_addr));

  // R4: strobe only falls after a cycle of valid address
  assert_as_after_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_as_n) |-> ($past(bus_addr_oe) && bus_addr_oe));

  // R5: data strobes only inside an address strobe
  assert_ds_inside_as_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_uds_n || !bus_lds_n) |-> !bus_as_n);

  // R7: completion pulse is a single cycle
  assert_rsp_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R8: write strobes only with data on the bus
  assert_wdata_under_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rw_n && (!bus_uds_n || !bus_lds_n)) |-> bus_data_oe);

  // R8 / R9: direction turns to write while no data strobe is active
  assert_rw_turn_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_rw_n) |-> (bus_uds_n && bus_lds_n));

  // R10: everything released after completion
  assert_release_after_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (bus_as_n && bus_uds_n && bus_lds_n && bus_rw_n && !bus_data_oe && !bus_addr_oe));

endmodule

bind abus_master abus_master_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_ready  (cmd_ready),
  .rsp_valid  (rsp_valid),
  .bus_addr   (bus_addr),
  .bus_addr_oe(bus_addr_oe),
  .bus_as_n   (bus_as_n),
  .bus_uds_n  (bus_uds_n),
  .bus_lds_n  (bus_lds_n),
  .bus_rw_n   (bus_rw_n),
  .bus_data_oe(bus_data_oe)
);

// File: tb/test_abus_master.sv
`timescale 1ns/1ps
module test_abus_master;

  localparam int AW = 16;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [1:0]    cmd_op = 2'b00;
  logic [AW-1:0] cmd_addr = '0;
  logic [1:0]    cmd_be = 2'b11;
  logic [DW-1:0] cmd_wdata = '0;
  logic          rsp_valid;
  logic [DW-1:0] rsp_data;
  logic [AW-1:0] bus_addr;
  logic          bus_addr_oe, bus_as_n, bus_uds_n, bus_lds_n, bus_rw_n, bus_data_oe;
  logic [DW-1:0] bus_wdata;
  logic [DW-1:0] bus_rdata;
  logic          bus_dtack_n = 1'b1;

  always #2.5 clk = ~clk;

  abus_master #(.ADDR_W(AW), .DATA_W(DW)) i_abus_master (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_be(cmd_be), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .bus_addr(bus_addr),
    .bus_addr_oe(bus_addr_oe), .bus_as_n(bus_as_n), .bus_uds_n(bus_uds_n),
    .bus_lds_n(bus_lds_n), .bus_rw_n(bus_rw_n), .bus_wdata(bus_wdata),
    .bus_data_oe(bus_data_oe), .bus_rdata(bus_rdata), .bus_dtack_n(bus_dtack_n)
  );

  int checks = 0;
  int fails  = 0;

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, what, act, act, exp, exp);
    end
  endtask

  // ---------------- slave model ----------------
  logic [DW-1:0] slv_mem [16];
  logic [DW-1:0] shadow  [16];
  int            slv_dly = 0;
  int            slv_cnt = 0;

  assign bus_rdata = slv_mem[bus_addr[3:0]];

  always @(negedge clk) begin
    if (!bus_as_n && (!bus_uds_n || !bus_lds_n)) begin
      if (slv_cnt >= slv_dly) bus_dtack_n <= 1'b0;
      slv_cnt++;
      if (!bus_rw_n && (slv_cnt > slv_dly)) begin
        if (!bus_uds_n) slv_mem[bus_addr[3:0]][15:8] <= bus_wdata[15:8];
        if (!bus_lds_n) slv_mem[bus_addr[3:0]][7:0]  <= bus_wdata[7:0];
      end
    end else begin
      slv_cnt = 0;
      bus_dtack_n <= 1'b1;
    end
  end

  // ---------------- scoreboard ----------------
  typedef struct {
    int data; int lat; int rd_cyc; int wr_cyc; int u_cyc; int l_cyc;
    int falls; int addr; int wdata; bit is_rmw; bit is_wr;
  } exp_t;

  exp_t exp_q[$];
  bit   go = 0;
  bit   in_flight = 0;
  bit   idle_chk = 0;

  int lat, rd_cyc, wr_cyc, u_cyc, l_cyc, falls, as_rises, addr_err, wd_err;
  bit prev_ds_low, prev_as_n;

  always @(negedge clk) begin
    if (idle_chk) begin
      idle_chk = 0;
      check("R10", "released bus after response",
            {bus_as_n, bus_uds_n, bus_lds_n, bus_rw_n, bus_addr_oe, bus_data_oe}, 6'b111100);
    end
    if (go) begin
      go = 0; in_flight = 1;
      lat = 0; rd_cyc = 0; wr_cyc = 0; u_cyc = 0; l_cyc = 0; falls = 0;
      as_rises = 0; addr_err = 0; wd_err = 0; prev_ds_low = 0; prev_as_n = 1;
      check("R3", "address floated in S0", {bus_addr_oe, (bus_addr != 0)}, 0);
    end
    if (in_flight) begin
      exp_t e;
      bit ds_low;
      e = exp_q[0];
      lat++;
      ds_low = !bus_uds_n || !bus_lds_n;
      if (ds_low && bus_rw_n)  rd_cyc++;
      if (ds_low && !bus_rw_n) begin
        wr_cyc++;
        if (!bus_data_oe || bus_wdata != e.wdata[15:0]) wd_err++;
      end
      if (!bus_uds_n) u_cyc++;
      if (!bus_lds_n) l_cyc++;
      if (ds_low && !prev_ds_low) falls++;
      if (bus_as_n && !prev_as_n) as_rises++;
      if (lat >= 2 && (!bus_addr_oe || bus_addr != e.addr[AW-1:0])) addr_err++;
      prev_ds_low = ds_low;
      prev_as_n   = bus_as_n;
      if (rsp_valid) begin
        void'(exp_q.pop_front());
        in_flight = 0;
        idle_chk  = 1;
        check(e.is_rmw ? "R9" : (e.is_wr ? "R8" : "R6"), "response latency", lat, e.lat);
        check(e.is_rmw ? "R9" : (e.is_wr ? "R8" : "R7"), "response data", rsp_data, e.data);
        check("R5", "read-level strobe cycles", rd_cyc, e.rd_cyc);
        check("R8", "write-level strobe cycles", wr_cyc, e.wr_cyc);
        check("R5", "upper strobe cycles", u_cyc, e.u_cyc);
        check("R5", "lower strobe cycles", l_cyc, e.l_cyc);
        check(e.is_rmw ? "R9" : "R5", "data strobe pulses", falls, e.falls);
        check(e.is_rmw ? "R9" : "R4", "address strobe releases", as_rises, 1);
        check("R3", "address errors from S1", addr_err, 0);
        check("R8", "write data errors under strobe", wd_err, 0);
      end
    end
  end

  task automatic run_op(input logic [1:0] op, input int a, input logic [1:0] be,
                        input logic [15:0] wd, input int d);
    exp_t e;
    logic [1:0]  ln;
    logic [15:0] m;
    int k, ds_tot;
    ln = (be == 2'b00) ? 2'b11 : be;
    m  = {{8{ln[1]}}, {8{ln[0]}}};
    k  = (d + 1) / 2;
    e.addr = a; e.wdata = wd; e.is_rmw = (op == 2'b10); e.is_wr = (op == 2'b01);
    if (op == 2'b01) begin
      e.data = 0; e.lat = 10 + 2*k; e.rd_cyc = 0; e.wr_cyc = 5 + 2*k; e.falls = 1;
    end else if (op == 2'b10) begin
      e.data = shadow[a] & m; e.lat = 16 + 4*k; e.rd_cyc = 5 + 2*k; e.wr_cyc = 5 + 2*k; e.falls = 2;
    end else begin
      e.data = shadow[a] & m; e.lat = 8 + 2*k; e.rd_cyc = 5 + 2*k; e.wr_cyc = 0; e.falls = 1;
    end
    ds_tot  = e.rd_cyc + e.wr_cyc;
    e.u_cyc = ln[1] ? ds_tot : 0;
    e.l_cyc = ln[0] ? ds_tot : 0;
    if (op == 2'b01 || op == 2'b10) shadow[a] = (shadow[a] & ~m) | (wd & m);
    exp_q.push_back(e);
    @(negedge clk);
    slv_dly = d; cmd_op = op; cmd_addr = AW'(a); cmd_be = be; cmd_wdata = wd; cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(posedge clk);
    #1;
    cmd_valid = 1'b0; go = 1;
    #1;
    check("R2", "ready dropped after acceptance", cmd_ready, 0);
    wait (!in_flight && !go);
  endtask

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL R6 watchdog: cycles %0d expected below %0d", cyc, 100000);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      slv_mem[i] = 16'h1234 + 16'(i) * 16'h0F1D;
      shadow[i]  = slv_mem[i];
    end
    repeat (3) @(negedge clk);
    check("R1", "reset outputs",
          {cmd_ready, bus_as_n, bus_uds_n, bus_lds_n, bus_rw_n, bus_addr_oe, bus_data_oe, rsp_valid},
          8'b11111000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "idle after reset release",
          {cmd_ready, bus_as_n, bus_uds_n, bus_lds_n, bus_rw_n, bus_addr_oe, bus_data_oe, rsp_valid},
          8'b11111000);

    run_op(2'b00, 3, 2'b11, 16'h0000, 0);   // R6 zero-wait word read
    run_op(2'b00, 4, 2'b10, 16'h0000, 1);   // R5 upper lane, one pair
    run_op(2'b00, 5, 2'b01, 16'h0000, 2);   // R5 lower lane
    run_op(2'b00, 6, 2'b11, 16'h0000, 3);   // R6 two pairs
    run_op(2'b00, 7, 2'b11, 16'h0000, 6);   // R6 three pairs
    run_op(2'b01, 5, 2'b11, 16'hBEEF, 0);   // R8 word write
    run_op(2'b01, 6, 2'b10, 16'hA1B2, 1);   // R8 upper-only write
    run_op(2'b01, 7, 2'b01, 16'hC3D4, 4);   // R8 lower-only write
    run_op(2'b00, 5, 2'b11, 16'h0000, 0);   // R7 read back
    run_op(2'b00, 6, 2'b11, 16'h0000, 0);
    run_op(2'b00, 7, 2'b11, 16'h0000, 1);
    run_op(2'b10, 9, 2'b11, 16'h5A5A, 0);   // R9 locked pair, tightest acknowledge turnaround
    run_op(2'b10, 10, 2'b01, 16'h0F0F, 3);  // R9 lower lane with waits
    run_op(2'b10, 11, 2'b10, 16'h7788, 1);
    run_op(2'b00, 9, 2'b11, 16'h0000, 0);   // R9 read back
    run_op(2'b00, 10, 2'b11, 16'h0000, 2);
    run_op(2'b00, 11, 2'b11, 16'h0000, 0);
    run_op(2'b00, 12, 2'b00, 16'h0000, 0);  // R5 enables 00 act as word
    run_op(2'b11, 13, 2'b11, 16'h0000, 1);  // R2 opcode 11 reads
    run_op(2'b01, 14, 2'b00, 16'h9999, 2);  // R5 word write via 00
    run_op(2'b00, 14, 2'b11, 16'h0000, 5);

    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule